// File: doc/BRIEF.md
# Adjustment Register Bus Slave

This block is a two-wire serial bus slave that loads a bank of byte-wide adjustment registers and answers with a single status byte. It runs entirely on the system clock. SCL and SDA are oversampled, and each line passes through a synchronizer and a stability filter before any decoding, so short spikes never reach the protocol logic. The device address is fixed: 0x8C selects a write and 0x8D selects a read. Bytes travel most significant bit first.

A write carries a subaddress byte and then one or more data bytes. Each data byte lands at the current subaddress, and the subaddress then steps by one. This lets a host reload the whole bank in a single burst. A read needs no subaddress: every byte the slave returns is the status byte, which holds the horizontal lock flag and the X-ray latch flag.

One register is a command register with two action bits. Bit 7 reloads every register with its default. Bit 6 sends a one-cycle clear strobe to the external X-ray latch. The block drives SDA only through an open-drain enable output. The pad, the converters fed by the registers and clock stretching are all outside this block.

Top module: `adjreg_i2c_slave`

## Requirements
- R1: After a start, an address byte of 0x8C (write) or 0x8D (read) is acknowledged by pulling SDA low during the ninth clock. Any other address byte is not acknowledged, and every later bit up to the next start or stop leaves the registers unchanged.
- R2: In a write, bytes are taken MSB first. The byte after the address is the subaddress, and the next byte is written to the register at that subaddress. Every byte of a write is acknowledged.
- R3: Each further data byte in the same write goes to the subaddress one above the previous one, until a stop or a repeated start.
- R4: A data byte aimed at a subaddress at or above NUM_REGS (default 20) is acknowledged but changes no register.
- R5: In a read, the slave shifts out the status byte MSB first. Bits 7..2 are 0, bit 1 is pll_unlocked and bit 0 is xray_latched, sampled when the byte starts. A master acknowledge makes the slave send the status byte again. A master non-acknowledge ends the transfer.
- R6: A stop ends all activity and releases SDA. A repeated start returns the slave to the address phase, and a new subaddress is then needed.
- R7: A pulse on SCL or SDA that lasts fewer than FILT_CYCLES clocks (default 7, 56 ns at 125 MHz) is ignored.
- R8: While rst_n is low, every register takes its default value: 0x40 for each register except the command register at subaddress CMD_ADDR (default 17), whose default is 0x00.
- R9: Writing the command register with bit 7 set loads every register with its default. Bit 7 itself is not stored.
- R10: Writing the command register with bit 6 set raises xray_clr for exactly one clock, and bit 6 is not stored. Bits 5..0 of a command write are stored.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| pll_unlocked | input | 1 | High while the horizontal loop is not locked |
| xray_latched | input | 1 | High while the X-ray protection latch is set |
| sda_oe | output | 1 | High to pull SDA low (open-drain enable) |
| regs_flat | output | NUM_REGS*8 | Register contents; register i occupies bits i*8+7..i*8 |
| xray_clr | output | 1 | One-cycle strobe that clears the X-ray latch |

## Verification
The assertions assume that each SCL high or low phase lasts much longer than the input filter delay. They also assume that SDA is moved by the master only while SCL is low, except at start and stop, and that a start or stop is never issued while the slave is driving SDA. The status inputs are taken to be synchronous to clk. The stimulus respects these assumptions by holding each quarter bit for 25 clocks and by issuing start and stop only after the slave has released the line. Injected spikes last 3 clocks, well below the filter length, and are placed away from the slave's own SDA updates.

// File: rtl/adjreg_i2c_pkg.sv
// Shared constants, types and default values for the adjustment register slave.
// Assumes 8-bit subaddresses and one command register inside the bank.
package adjreg_i2c_pkg;

    localparam int          BYTE_W      = 8;
    localparam logic [7:0]  ADDR_WRITE  = 8'h8C;
    localparam logic [7:0]  ADDR_READ   = 8'h8D;
    localparam int          SRST_BIT    = 7;
    localparam int          XCLR_BIT    = 6;
    localparam logic [7:0]  CMD_KEEP    = 8'h3F;
    localparam logic [7:0]  DAC_DEFAULT = 8'h40;
    localparam logic [7:0]  CMD_DEFAULT = 8'h00;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUB,
        PH_DATA,
        PH_READ
    } phase_t;

    // Default content of one register; the command register differs from the rest.
    function automatic logic [7:0] reg_default(input logic is_cmd);
        return is_cmd ? CMD_DEFAULT : DAC_DEFAULT;
    endfunction

endpackage

// File: rtl/adjreg_i2c_filter.sv
// Synchronizes one bus line and passes a new level only after it has held
// for STABLE_CYCLES consecutive clocks. Assumes the idle level is high.
module adjreg_i2c_filter #(
    parameter int STABLE_CYCLES = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_clean
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] hold_cnt;

    // Two-flop synchronizer, then a run-length counter that accepts a level change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q     <= 2'b11;
            hold_cnt   <= '0;
            line_clean <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_raw};
            if (sync_q[1] == line_clean) begin
                hold_cnt <= '0;
            end else if (hold_cnt == CNT_W'(STABLE_CYCLES - 1)) begin
                line_clean <= sync_q[1];
                hold_cnt   <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/adjreg_i2c_proto.sv
// Bus protocol engine: detects start and stop, shifts bytes MSB first,
// acknowledges, auto-increments the subaddress and serves the status byte.
// Assumes filtered lines whose phases last many clocks.
module adjreg_i2c_proto
    import adjreg_i2c_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_f,
    input  logic        sda_f,
    input  logic [7:0]  status_byte,
    output logic        sda_oe,
    output logic        wr_en,
    output logic [7:0]  wr_addr,
    output logic [7:0]  wr_data,
    output phase_t      phase
);
    logic       scl_d, sda_d;
    logic       is_start, is_stop, scl_rise, scl_fall;
    logic [3:0] bit_cnt;
    logic [7:0] rx_shift;
    logic [7:0] tx_shift;
    logic [7:0] sub_ptr;
    logic       is_read;

    // One-cycle history of the filtered lines for edge and condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    // Decode bus conditions from the current and previous line levels.
    always_comb begin
        is_start = scl_f && scl_d && sda_d && !sda_f;
        is_stop  = scl_f && scl_d && !sda_d && sda_f;
        scl_rise = scl_f && !scl_d;
        scl_fall = !scl_f && scl_d;
    end

    // Main sequencer: bit counting, acknowledge slots, writes and status shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            rx_shift <= '0;
            tx_shift <= '0;
            sub_ptr  <= '0;
            is_read  <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (is_stop) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (is_start) begin
                phase   <= PH_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise) begin
                    if (bit_cnt < 4'd8) begin
                        if (phase != PH_READ) begin
                            rx_shift <= {rx_shift[6:0], sda_f};
                        end
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (bit_cnt == 4'd9 && phase == PH_READ && sda_f) begin
                        phase <= PH_IDLE;
                    end
                end
                if (scl_fall) begin
                    if (bit_cnt == 4'd8) begin
                        bit_cnt <= 4'd9;
                        case (phase)
                            PH_ADDR: begin
                                if (rx_shift == ADDR_WRITE) begin
                                    is_read <= 1'b0;
                                    sda_oe  <= 1'b1;
                                end else if (rx_shift == ADDR_READ) begin
                                    is_read <= 1'b1;
                                    sda_oe  <= 1'b1;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            PH_SUB: begin
                                sub_ptr <= rx_shift;
                                sda_oe  <= 1'b1;
                            end
                            PH_DATA: begin
                                wr_en   <= 1'b1;
                                wr_addr <= sub_ptr;
                                wr_data <= rx_shift;
                                sub_ptr <= sub_ptr + 8'd1;
                                sda_oe  <= 1'b1;
                            end
                            default: begin
                                sda_oe <= 1'b0;
                            end
                        endcase
                    end else if (bit_cnt == 4'd9) begin
                        bit_cnt <= '0;
                        sda_oe  <= 1'b0;
                        case (phase)
                            PH_ADDR: begin
                                if (is_read) begin
                                    phase    <= PH_READ;
                                    tx_shift <= status_byte;
                                    sda_oe   <= ~status_byte[7];
                                end else begin
                                    phase <= PH_SUB;
                                end
                            end
                            PH_SUB:  phase <= PH_DATA;
                            PH_READ: begin
                                tx_shift <= status_byte;
                                sda_oe   <= ~status_byte[7];
                            end
                            default: phase <= phase;
                        endcase
                    end else if (phase == PH_READ && bit_cnt != 4'd0) begin
                        tx_shift <= {tx_shift[6:0], 1'b0};
                        sda_oe   <= ~tx_shift[6];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/adjreg_i2c_bank.sv
// Register bank: one byte register per subaddress with defaults, a command
// register whose action bits reload defaults or pulse the latch clear.
// Assumes CMD_ADDR lies below NUM_REGS; writes past the bank are dropped.
module adjreg_i2c_bank
    import adjreg_i2c_pkg::*;
#(
    parameter int NUM_REGS = 20,
    parameter int CMD_ADDR = 17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_addr,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] regs_flat,
    output logic                  xray_clr
);
    localparam logic [7:0] CMD_SUB = 8'(CMD_ADDR);

    logic cmd_hit;
    logic soft_reset;

    // Decode command register actions from the current write.
    always_comb begin
        cmd_hit    = wr_en && (wr_addr == CMD_SUB);
        soft_reset = cmd_hit && wr_data[SRST_BIT];
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] MY_SUB  = 8'(g);
        localparam logic       MY_CMD  = (g == CMD_ADDR);
        localparam logic [7:0] MY_DEF  = reg_default(MY_CMD);
        localparam logic [7:0] MY_KEEP = MY_CMD ? CMD_KEEP : 8'hFF;
        logic [7:0] value_q;

        // Hold one register: defaults on reset or soft reset, else accept a hit.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_reset) begin
                value_q <= MY_DEF;
            end else if (wr_en && wr_addr == MY_SUB) begin
                value_q <= wr_data & MY_KEEP;
            end
        end

        assign regs_flat[g*8 +: 8] = value_q;
    end

    // One-cycle clear strobe for the external X-ray latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xray_clr <= 1'b0;
        end else begin
            xray_clr <= cmd_hit && wr_data[XCLR_BIT];
        end
    end

endmodule

// File: rtl/adjreg_i2c_slave.sv
// Top level: filters both bus lines, runs the protocol engine and holds the
// register bank. Assumes bus lines that are slow next to clk and status
// inputs synchronous to clk.
module adjreg_i2c_slave
    import adjreg_i2c_pkg::*;
#(
    parameter int NUM_REGS    = 20,
    parameter int CMD_ADDR    = 17,
    parameter int FILT_CYCLES = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    input  logic                  pll_unlocked,
    input  logic                  xray_latched,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] regs_flat,
    output logic                  xray_clr
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] clean_lines;
    logic [7:0]       status_w;
    logic             wr_en_w;
    logic [7:0]       wr_addr_w;
    logic [7:0]       wr_data_w;
    phase_t           phase_w;

    assign raw_lines = {sda_in, scl_in};
    assign status_w  = {6'b000000, pll_unlocked, xray_latched};

    for (genvar l = 0; l < LINES; l++) begin : g_filt
        adjreg_i2c_filter #(
            .STABLE_CYCLES(FILT_CYCLES)
        ) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_raw  (raw_lines[l]),
            .line_clean(clean_lines[l])
        );
    end

    adjreg_i2c_proto u_proto (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_f      (clean_lines[0]),
        .sda_f      (clean_lines[1]),
        .status_byte(status_w),
        .sda_oe     (sda_oe),
        .wr_en      (wr_en_w),
        .wr_addr    (wr_addr_w),
        .wr_data    (wr_data_w),
        .phase      (phase_w)
    );

    adjreg_i2c_bank #(
        .NUM_REGS(NUM_REGS),
        .CMD_ADDR(CMD_ADDR)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_w),
        .wr_addr  (wr_addr_w),
        .wr_data  (wr_data_w),
        .regs_flat(regs_flat),
        .xray_clr (xray_clr)
    );

endmodule

// File: rtl/adjreg_i2c_checker.sv
// Property checker for the adjustment register slave, bound into the top.
// Assumes slow bus lines and a master that never stops while the slave drives.
module adjreg_i2c_checker
    import adjreg_i2c_pkg::*;
#(
    parameter int NUM_REGS = 20,
    parameter int CMD_ADDR = 17
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_in,
    input logic                  sda_oe,
    input logic                  xray_clr,
    input logic [NUM_REGS*8-1:0] regs_flat,
    input phase_t                phase,
    input logic                  wr_en
);
    // Expected bank contents after any reset.
    function automatic logic [NUM_REGS*8-1:0] all_defaults();
        logic [NUM_REGS*8-1:0] v;
        for (int i = 0; i < NUM_REGS; i++) begin
            v[i*8 +: 8] = reg_default(i == CMD_ADDR);
        end
        return v;
    endfunction

    localparam logic [NUM_REGS*8-1:0] DEF_FLAT = all_defaults();

    AST_POR_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (regs_flat == DEF_FLAT)); // R8

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xray_clr |=> !xray_clr); // R10

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_oe); // R6

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_in); // R11

    AST_REGS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$stable(regs_flat) |-> $past(wr_en)); // R2

endmodule

bind adjreg_i2c_slave adjreg_i2c_checker #(
    .NUM_REGS(NUM_REGS),
    .CMD_ADDR(CMD_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_oe   (sda_oe),
    .xray_clr (xray_clr),
    .regs_flat(regs_flat),
    .phase    (phase_w),
    .wr_en    (wr_en_w)
);

// File: tb/adjreg_i2c_slave_test.sv
// Bench for the adjustment register slave: a bus master model, a reference
// register model and directed plus seeded random transfers.
module adjreg_i2c_slave_test;
    localparam int N   = 20;
    localparam int CMD = 17;
    localparam int Q   = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic pll_unlocked = 1'b0;
    logic xray_latched = 1'b0;
    logic sda_oe;
    logic [N*8-1:0] regs_flat;
    logic xray_clr;
    logic sda_line;

    int total = 0;
    int bad = 0;
    int clr_seen = 0;
    int clr_exp = 0;
    bit done = 0;
    bit spike_en = 0;
    logic [7:0] model [N];

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    adjreg_i2c_slave #(.NUM_REGS(N), .CMD_ADDR(CMD), .FILT_CYCLES(7)) uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .pll_unlocked(pll_unlocked), .xray_latched(xray_latched),
        .sda_oe(sda_oe), .regs_flat(regs_flat), .xray_clr(xray_clr)
    );

    // Count latch-clear strobes seen at the port.
    always @(posedge clk) if (rst_n && xray_clr) clr_seen++;

    function automatic logic [7:0] def_of(int i);
        return (i == CMD) ? 8'h00 : 8'h40;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) model[i] = def_of(i);
    endtask

    // Reference effect of one data byte at subaddress s.
    task automatic model_write(int s, logic [7:0] d);
        if (s < N) begin
            if (s == CMD) begin
                if (d[6]) clr_exp++;
                if (d[7]) model_reset();
                else model[s] = d & 8'h3F;
            end else begin
                model[s] = d;
            end
        end
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic check_regs(string req);
        int first = -1;
        total++;
        for (int i = 0; i < N; i++)
            if (first < 0 && regs_flat[i*8 +: 8] !== model[i]) first = i;
        if (first >= 0) begin
            bad++;
            $display("FAIL %s reg%0d actual=%0h expected=%0h", req, first,
                     regs_flat[first*8 +: 8], model[first]);
        end
    endtask

    task automatic wq(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    // One bit slot; returns the line level at mid-high. Optional spikes.
    task automatic bit_slot(logic b, output logic seen);
        sda_m = b;
        if (spike_en) begin
            wq(8); scl_m = 1'b1; wq(3); scl_m = 1'b0; wq(Q - 11);
        end else wq(Q);
        scl_m = 1'b1;
        if (spike_en && b) begin
            wq(10); sda_m = 1'b0; wq(3); sda_m = 1'b1; wq(Q - 13);
        end else wq(Q);
        seen = sda_line;
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_slot(b[i], s);
        bit_slot(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(logic master_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_slot(1'b1, s);
            b[i] = s;
        end
        bit_slot(~master_ack, s);
    endtask

    // Complete write transfer with model update and acknowledge checks.
    task automatic write_burst(int sub, logic [7:0] d [], string req);
        logic a;
        bus_start();
        send_byte(8'h8C, a); check({req, " addr ack"}, a, 1);
        send_byte(8'(sub), a); check({req, " sub ack"}, a, 1);
        foreach (d[i]) begin
            send_byte(d[i], a);
            check({req, " data ack"}, a, 1);
            model_write((sub + i) & 8'hFF, d[i]);
        end
        bus_stop();
        wq(4);
    endtask

    task automatic read_status(logic unl, logic xr, string req);
        logic a;
        logic [7:0] b;
        pll_unlocked = unl; xray_latched = xr;
        bus_start();
        send_byte(8'h8D, a); check({req, " read addr ack"}, a, 1);
        recv_byte(1'b1, b); check({req, " status first"}, b, {6'b0, unl, xr});
        recv_byte(1'b0, b); check({req, " status repeat"}, b, {6'b0, unl, xr});
        bus_stop();
        wq(4);
        check("R6 released after stop", sda_oe, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] d [];
        void'($urandom(32'd7741));
        model_reset();
        wq(10);
        rst_n = 1'b1;
        wq(4);
        check_regs("R8 power-on defaults");
        check("R6 idle release", sda_oe, 0);

        // R2: single write
        d = new[1]; d[0] = 8'hA5;
        write_burst(3, d, "R2");
        check_regs("R2 single write");

        // R3 and R4: burst running off the end of the bank
        d = new[3]; d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
        write_burst(18, d, "R4");
        check_regs("R3 R4 burst past end");

        // R1: foreign address is not acknowledged and the rest is ignored
        bus_start();
        send_byte(8'h8E, a); check("R1 foreign addr nack", a, 0);
        send_byte(8'h02, a); check("R1 ignored byte nack", a, 0);
        send_byte(8'h77, a);
        bus_stop();
        wq(4);
        check_regs("R1 foreign addr no write");

        // R5: status patterns
        read_status(1'b1, 1'b0, "R5");
        read_status(1'b0, 1'b1, "R5");
        read_status(1'b1, 1'b1, "R5");

        // R6: repeated start needs a new subaddress
        bus_start();
        send_byte(8'h8C, a); send_byte(8'd5, a); send_byte(8'h12, a);
        model_write(5, 8'h12);
        bus_start();
        send_byte(8'h8C, a); send_byte(8'd7, a); send_byte(8'h34, a);
        model_write(7, 8'h34);
        bus_stop();
        wq(4);
        check_regs("R6 repeated start");

        // R10: latch clear strobe and stored low bits
        d = new[1]; d[0] = 8'h45;
        write_burst(CMD, d, "R10");
        check_regs("R10 command bits stored");
        check("R10 clear strobe count", clr_seen, clr_exp);

        // R7: spikes on both lines during a burst
        spike_en = 1;
        d = new[2]; d[0] = 8'hC3; d[1] = 8'hFF;
        write_burst(9, d, "R7");
        spike_en = 0;
        check_regs("R7 spikes ignored");

        // Seeded random bursts, compared against the model
        for (int t = 0; t < 14; t++) begin
            int sub = $urandom_range(0, N + 1);
            d = new[$urandom_range(1, 3)];
            foreach (d[i]) d[i] = 8'($urandom);
            write_burst(sub, d, "R3");
            check_regs("R3 random burst");
        end
        check("R10 random strobe count", clr_seen, clr_exp);

        // R9: soft reset via command bit 7
        d = new[1]; d[0] = 8'h80;
        write_burst(CMD, d, "R9");
        check_regs("R9 soft reset defaults");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule